// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Engine

This block multiplies two 32-bit operands, shapes the product according to a programmable number format, and adds it into one of four 48-bit accumulators, detecting overflow and optionally clamping the result. Three formats are supported: signed integer, unsigned integer and signed fractional. Each format has its own overflow limits and clamp values. A status word carries the format bits, the condition flags N, Z, V and EV, and one sticky overflow bit per accumulator.

Commands arrive on a valid/ready stream. The unit never applies back-pressure: `cmd_ready` is held high. Every cycle in which `cmd_valid` is high, one command is consumed. The result lands in the accumulators and status at that clock edge. `done` is high for exactly the cycle that follows. Back-to-back commands are allowed, and each one sees the state left by the one before. Besides multiply-accumulate, the command set copies one accumulator into another, evaluates flags from an accumulator, and loads the format bits. The accumulators can be read at any time through a combinational read port.

Top module: `mac_sat_unit`

## Requirements
- R1: A synchronous active-high reset clears all four accumulators, all sticky bits, the flags N, Z, V and EV, the format bits and `done`.
- R2: Each cycle with `cmd_valid` high consumes one command, and `cmd_ready` is always 1. The command code is on `cmd_op`: 0 is multiply-accumulate, 1 is move, 2 is flag update and 3 is format load. State changes at the accepting edge, and `done` is 1 for exactly the next cycle.
- R3: In signed integer format (bit0 of the format set, bit1 clear), a product outside the 40-bit signed range sets V and the target's sticky bit. With clamping off, the product is cut to its low 40 bits and sign-extended before the add. With clamping on, the accumulator ends at 0x0000_7FFF_FFFF for a positive product or 0xFFFF_8000_0000 for a negative one.
- R4: In unsigned format (bits 0 and 1 clear), operands are unsigned. A product with any bit from 40 up set raises V and the sticky bit. With clamping off, the product is cut to 40 bits. With clamping on, the accumulator saturates to 0xFFFF_FFFF_FFFF.
- R5: In fractional format (bit1 set), the signed product is shifted right arithmetically by 24. With the round bit (bit2) set, a discarded part above 0x800000 rounds up, and a discarded part of exactly 0x800000 rounds to the even result. With the round bit clear, the discarded part is dropped.
- R6: In signed integer format, a sum outside the 48-bit signed range sets V and the target's sticky bit. Without clamping (bit3 clear), the low 48 bits are kept. With clamping, the result is 0x0000_7FFF_FFFF or 0xFFFF_8000_0000, chosen by the sign of the sum. No command other than a move ever clears a sticky bit.
- R7: In fractional format with clamping, an out-of-range sum becomes 0x7FFF_FFFF_FFFF when positive or 0x8000_0000_0000 when negative. V and the sticky bit are set.
- R8: In unsigned format, a sum with a bit at 48 or above raises V and the sticky bit. Without clamping, the sum is cut to 48 bits. With clamping, the result is 0xFFFF_FFFF_FFFF, or 0 if the sum exceeds 2^53.
- R9: A flag update on accumulator `cmd_acc` sets Z when the accumulator is zero. Otherwise it sets N when bit 47 is 1. Flags are only ever set by this command and are never cleared by it.
- R10: A flag update sets V when that accumulator's sticky bit is 1. It sets EV when the bits above the active data field are not a pure sign extension. The field is 40 bits in fractional format and 32 bits in signed format. In unsigned format, EV is set when bits 47..32 are not all zero.
- R11: A move copies accumulator `cmd_src` into accumulator `cmd_acc`, and copies the source's sticky bit into the destination's sticky bit.
- R12: A format load writes `cmd_mode` into the format bits: bit0 signed, bit1 fractional, bit2 round, bit3 clamp. It clears N, Z, V and EV, and leaves the accumulators and sticky bits unchanged.
- R13: In a cycle with `cmd_valid` low, no accumulator, sticky bit, flag or format bit changes, whatever the other command inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_ready | output | 1 | Always 1; the unit takes a command every cycle |
| cmd_op | input | 2 | Command code: 0 MAC, 1 move, 2 flags, 3 format load |
| cmd_acc | input | 2 | Target accumulator (destination for a move) |
| cmd_src | input | 2 | Source accumulator for a move |
| cmd_a | input | 32 | First multiplier operand |
| cmd_b | input | 32 | Second multiplier operand |
| cmd_mode | input | 4 | Format bits for a format load |
| done | output | 1 | High the cycle after a command was consumed |
| rd_sel | input | 2 | Accumulator shown on `rd_acc` |
| rd_acc | output | 48 | Value of accumulator `rd_sel` |
| mode_o | output | 4 | Current format bits |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_ev | output | 1 | Extension-overflow flag |
| sticky_ov | output | 4 | Sticky overflow bit per accumulator |

## Verification
Every command's effect is due one clock edge after it is driven. Accumulators, sticky bits, flags, format bits and `done` all update at the accepting edge. The bench drives each command just after a falling edge and holds it for one cycle. It then checks `done` at the next falling edge, and the state right after that, while no command is pending. In the long overflow runs, commands are streamed back to back, and the checks wait until the stream has ended and the final command has settled.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;

  typedef enum logic [1:0] {
    OP_MAC   = 2'd0,
    OP_MOVE  = 2'd1,
    OP_FLAGS = 2'd2,
    OP_MODE  = 2'd3
  } mac_op_e;

  typedef struct packed {
    logic sat;
    logic rnd;
    logic frc;
    logic sgn;
  } mac_mode_t;

endpackage

// File: rtl/mac_product.sv
module mac_product #(
  parameter int OP_W      = 32,
  parameter int FIT_W     = 40,
  parameter int FRAC_SH   = 24,
  parameter int FORCE_BIT = 50
) (
  input  logic [OP_W-1:0]        a_i,
  input  logic [OP_W-1:0]        b_i,
  input  mac_sat_pkg::mac_mode_t mode_i,
  output logic [2*OP_W-1:0]      prod_o,
  output logic                   ovf_o
);
  localparam int PW = 2 * OP_W;
  localparam logic [PW-1:0]      FORCE_V = PW'(1) << FORCE_BIT;
  localparam logic [FRAC_SH-1:0] HALF    = FRAC_SH'(1) << (FRAC_SH - 1);

  logic [PW-1:0]      p_s, p_u, p_sh;
  logic [FRAC_SH-1:0] rem;
  logic               fit, rnd_up, u_big;

  assign p_s    = {{OP_W{a_i[OP_W-1]}}, a_i} * {{OP_W{b_i[OP_W-1]}}, b_i};
  assign p_u    = {{OP_W{1'b0}}, a_i} * {{OP_W{1'b0}}, b_i};
  assign p_sh   = PW'($signed(p_s) >>> FRAC_SH);
  assign rem    = p_s[FRAC_SH-1:0];
  assign rnd_up = mode_i.rnd && ((rem > HALF) || ((rem == HALF) && p_sh[0]));
  assign fit    = (&p_s[PW-1:FIT_W-1]) || !(|p_s[PW-1:FIT_W-1]);
  assign u_big  = |p_u[PW-1:FIT_W];

  always_comb begin
    ovf_o  = 1'b0;
    prod_o = p_u;
    if (mode_i.frc) begin
      prod_o = p_sh + PW'(rnd_up);
    end else if (mode_i.sgn) begin
      ovf_o = !fit;
      if (fit)             prod_o = p_s;
      else if (mode_i.sat) prod_o = p_s[PW-1] ? ~FORCE_V : FORCE_V;
      else                 prod_o = {{(PW-FIT_W){p_s[FIT_W-1]}}, p_s[FIT_W-1:0]};
    end else begin
      ovf_o = u_big;
      if (u_big) prod_o = mode_i.sat ? FORCE_V : {{(PW-FIT_W){1'b0}}, p_u[FIT_W-1:0]};
    end
  end
endmodule

// File: rtl/mac_accum_sat.sv
module mac_accum_sat #(
  parameter int ACC_W   = 48,
  parameter int OP_W    = 32,
  parameter int CLR_BIT = 53
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [2*OP_W-1:0] prod_i,
  input  logic              sgn_i,
  input  logic              frc_i,
  input  logic              sat_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              ovf_o
);
  localparam int PW  = 2 * OP_W;
  localparam int EXT = PW - ACC_W;
  localparam logic [ACC_W-1:0] INT_MAX = {{(ACC_W-OP_W+1){1'b0}}, {(OP_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] FRC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [PW-1:0]    CLR_LIM = PW'(1) << CLR_BIT;

  logic [PW-1:0] sum_s, sum_u;
  logic          s_fit, s_neg;

  assign sum_s = {{EXT{acc_i[ACC_W-1]}}, acc_i} + prod_i;
  assign sum_u = {{EXT{1'b0}}, acc_i} + prod_i;
  assign s_fit = (&sum_s[PW-1:ACC_W-1]) || !(|sum_s[PW-1:ACC_W-1]);
  assign s_neg = sum_s[PW-1];

  always_comb begin
    if (sgn_i || frc_i) begin
      ovf_o = !s_fit;
      acc_o = sum_s[ACC_W-1:0];
      if (!s_fit && sat_i) begin
        if (frc_i) acc_o = s_neg ? ~FRC_MAX : FRC_MAX;
        else       acc_o = s_neg ? ~INT_MAX : INT_MAX;
      end
    end else begin
      ovf_o = |sum_u[PW-1:ACC_W];
      acc_o = sum_u[ACC_W-1:0];
      if (ovf_o && sat_i) acc_o = (sum_u > CLR_LIM) ? '0 : '1;
    end
  end
endmodule

// File: rtl/mac_flag_eval.sv
module mac_flag_eval #(
  parameter int ACC_W = 48,
  parameter int OP_W  = 32,
  parameter int FIT_W = 40
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             sgn_i,
  input  logic             frc_i,
  output logic             zero_o,
  output logic             neg_o,
  output logic             ext_o
);
  logic [ACC_W-FIT_W:0] hi_f;
  logic [ACC_W-OP_W:0]  hi_s;
  logic                 f_bad, s_bad, u_bad;

  assign hi_f   = acc_i[ACC_W-1:FIT_W-1];
  assign hi_s   = acc_i[ACC_W-1:OP_W-1];
  assign f_bad  = !((&hi_f) || !(|hi_f));
  assign s_bad  = !((&hi_s) || !(|hi_s));
  assign u_bad  = |acc_i[ACC_W-1:OP_W];
  assign zero_o = (acc_i == '0);
  assign neg_o  = !zero_o && acc_i[ACC_W-1];
  assign ext_o  = frc_i ? f_bad : (sgn_i ? s_bad : u_bad);
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit #(
  parameter int NACC  = 4,
  parameter int ACC_W = 48,
  parameter int OP_W  = 32,
  parameter int SEL_W = $clog2(NACC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [SEL_W-1:0]  cmd_acc,
  input  logic [SEL_W-1:0]  cmd_src,
  input  logic [OP_W-1:0]   cmd_a,
  input  logic [OP_W-1:0]   cmd_b,
  input  logic [3:0]        cmd_mode,
  output logic              done,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [ACC_W-1:0]  rd_acc,
  output logic [3:0]        mode_o,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_ev,
  output logic [NACC-1:0]   sticky_ov
);
  import mac_sat_pkg::*;

  localparam int FIT_W     = ACC_W - 8;
  localparam int FRAC_SH   = OP_W - 8;
  localparam int FORCE_BIT = ACC_W + 2;
  localparam int CLR_BIT   = ACC_W + 5;

  mac_op_e          op;
  mac_mode_t        mode_q;
  logic [ACC_W-1:0] acc_q [NACC];
  logic [NACC-1:0]  sticky_q;
  logic [ACC_W-1:0] tgt_val, src_val, mac_nxt;
  logic             src_stk, tgt_stk;
  logic [2*OP_W-1:0] prod;
  logic             prod_ovf, sum_ovf, mac_ovf;
  logic             f_zero, f_neg, f_ext;
  logic             done_q, fn_q, fz_q, fv_q, fev_q;

  assign op      = mac_op_e'(cmd_op);
  assign tgt_val = acc_q[cmd_acc];
  assign src_val = acc_q[cmd_src];
  assign tgt_stk = sticky_q[cmd_acc];
  assign src_stk = sticky_q[cmd_src];
  assign mac_ovf = prod_ovf | sum_ovf;

  mac_product #(.OP_W(OP_W), .FIT_W(FIT_W), .FRAC_SH(FRAC_SH), .FORCE_BIT(FORCE_BIT)) u_prod (
    .a_i(cmd_a), .b_i(cmd_b), .mode_i(mode_q), .prod_o(prod), .ovf_o(prod_ovf)
  );

  mac_accum_sat #(.ACC_W(ACC_W), .OP_W(OP_W), .CLR_BIT(CLR_BIT)) u_acc (
    .acc_i(tgt_val), .prod_i(prod), .sgn_i(mode_q.sgn), .frc_i(mode_q.frc),
    .sat_i(mode_q.sat), .acc_o(mac_nxt), .ovf_o(sum_ovf)
  );

  mac_flag_eval #(.ACC_W(ACC_W), .OP_W(OP_W), .FIT_W(FIT_W)) u_flag (
    .acc_i(tgt_val), .sgn_i(mode_q.sgn), .frc_i(mode_q.frc),
    .zero_o(f_zero), .neg_o(f_neg), .ext_o(f_ext)
  );

  for (genvar gi = 0; gi < NACC; gi++) begin : g_acc
    logic [ACC_W-1:0] val_r;
    logic             stk_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        val_r <= '0;
        stk_r <= 1'b0;
      end else if (cmd_valid && cmd_acc == SEL_W'(gi)) begin
        if (op == OP_MAC) begin
          val_r <= mac_nxt;
          stk_r <= stk_r | mac_ovf;
        end else if (op == OP_MOVE) begin
          val_r <= src_val;
          stk_r <= src_stk;
        end
      end
    end
    assign acc_q[gi]    = val_r;
    assign sticky_q[gi] = stk_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      done_q <= 1'b0;
      fn_q   <= 1'b0;
      fz_q   <= 1'b0;
      fv_q   <= 1'b0;
      fev_q  <= 1'b0;
    end else begin
      done_q <= cmd_valid;
      if (cmd_valid) begin
        case (op)
          OP_MAC:   fv_q <= fv_q | mac_ovf;
          OP_FLAGS: begin
            fz_q  <= fz_q | f_zero;
            fn_q  <= fn_q | f_neg;
            fv_q  <= fv_q | tgt_stk;
            fev_q <= fev_q | f_ext;
          end
          OP_MODE: begin
            mode_q <= mac_mode_t'(cmd_mode);
            fn_q   <= 1'b0;
            fz_q   <= 1'b0;
            fv_q   <= 1'b0;
            fev_q  <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign cmd_ready = 1'b1;
  assign done      = done_q;
  assign rd_acc    = acc_q[rd_sel];
  assign mode_o    = mode_q;
  assign flag_n    = fn_q;
  assign flag_z    = fz_q;
  assign flag_v    = fv_q;
  assign flag_ev   = fev_q;
  assign sticky_ov = sticky_q;

  assert_done_after_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> done);
  assert_no_done_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !done);
  assert_idle_holds_state_R13: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> ($stable(sticky_q) && $stable(mode_q) && $stable(fv_q) && $stable(fev_q)));
  assert_sticky_not_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op != OP_MOVE) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
  assert_move_sticky_copy_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_MOVE) |=> (sticky_q[$past(cmd_acc)] == $past(src_stk)));
  assert_mode_load_clears_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_MODE) |=> (mode_q == $past(cmd_mode) && !fv_q && !fz_q));
  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_FLAGS && tgt_val == '0) |=> flag_z);
endmodule

// File: tb/mac_sat_unit_tb.sv
module mac_sat_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op, cmd_acc, cmd_src, rd_sel;
  logic [31:0] cmd_a, cmd_b;
  logic [3:0]  cmd_mode, mode_o, sticky_ov;
  logic        done, flag_n, flag_z, flag_v, flag_ev;
  logic [47:0] rd_acc;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  localparam logic [1:0] C_MAC = 2'd0, C_MOVE = 2'd1, C_FLAGS = 2'd2, C_MODE = 2'd3;

  always #2 clk = ~clk;

  mac_sat_unit u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_acc(cmd_acc), .cmd_src(cmd_src), .cmd_a(cmd_a),
    .cmd_b(cmd_b), .cmd_mode(cmd_mode), .done(done), .rd_sel(rd_sel),
    .rd_acc(rd_acc), .mode_o(mode_o), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_ev(flag_ev), .sticky_ov(sticky_ov)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_acc(input string tag, input int sel, input logic [47:0] exp);
    rd_sel = 2'(sel);
    #0.5;
    chk(tag, {16'h0, rd_acc}, {16'h0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input int acc, input int src,
                       input logic [31:0] a, input logic [31:0] b, input logic [3:0] md);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_acc = 2'(acc); cmd_src = 2'(src);
    cmd_a = a; cmd_b = b; cmd_mode = md;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic burst(input int acc, input logic [31:0] a, input logic [31:0] b, input int n);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = C_MAC; cmd_acc = 2'(acc); cmd_a = a; cmd_b = b;
    repeat (n) @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    for (int i = 0; i < 4; i++) chk_acc("R1 acc after reset", i, 48'h0);
    chk("R1 sticky", 64'(sticky_ov), 64'h0);
    chk("R1 mode", 64'(mode_o), 64'h0);
    chk("R1 flags", 64'({flag_n, flag_z, flag_v, flag_ev, done}), 64'h0);
    chk("R2 ready", 64'(cmd_ready), 64'h1);
  endtask

  task automatic t_signed_basic();
    do_reset();
    issue(C_MODE, 0, 0, 0, 0, 4'b0001);
    issue(C_MAC, 0, 0, 32'd3, 32'hFFFF_FFFB, 4'b0);
    chk("R2 done one cycle after", 64'(done), 64'h1);
    chk_acc("R2 signed 3*-5", 0, 48'hFFFF_FFFF_FFF1);
    @(negedge clk);
    chk("R2 done drops", 64'(done), 64'h0);
    issue(C_MAC, 0, 0, 32'd100, 32'd2, 4'b0);
    chk_acc("R2 signed accumulate", 0, 48'h0000_0000_00B9);
    chk("R2 no overflow V", 64'(flag_v), 64'h0);
  endtask

  task automatic t_signed_product_ovf();
    do_reset();
    issue(C_MODE, 0, 0, 0, 0, 4'b0001);
    issue(C_MAC, 1, 0, 32'h4000_0000, 32'h0000_0400, 4'b0);
    chk_acc("R3 truncated product", 1, 48'h0);
    chk("R3 V set", 64'(flag_v), 64'h1);
    chk("R3 sticky1", 64'(sticky_ov), 64'h2);
    issue(C_MODE, 0, 0, 0, 0, 4'b1001);
    chk("R12 V cleared", 64'(flag_v), 64'h0);
    chk("R12 mode loaded", 64'(mode_o), 64'h9);
    chk("R12 sticky kept", 64'(sticky_ov), 64'h2);
    issue(C_FLAGS, 1, 0, 0, 0, 4'b0);
    chk("R10 V from sticky", 64'(flag_v), 64'h1);
    chk("R9 zero acc", 64'({flag_z, flag_n}), 64'h2);
    issue(C_MAC, 2, 0, 32'h4000_0000, 32'hFFFF_FC00, 4'b0);
    chk_acc("R3 neg clamp", 2, 48'hFFFF_8000_0000);
    issue(C_MAC, 3, 0, 32'h4000_0000, 32'h0000_0400, 4'b0);
    chk_acc("R3 pos clamp", 3, 48'h0000_7FFF_FFFF);
    chk("R3 sticky set", 64'(sticky_ov), 64'hE);
  endtask

  task automatic t_unsigned();
    do_reset();
    issue(C_MAC, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0);
    chk_acc("R4 truncated 40b product", 1, 48'h00FE_0000_0001);
    chk("R4 V", 64'(flag_v), 64'h1);
    chk("R4 sticky", 64'(sticky_ov), 64'h2);
    issue(C_MODE, 0, 0, 0, 0, 4'b1000);
    issue(C_MAC, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0);
    chk_acc("R4 clamp all ones", 0, 48'hFFFF_FFFF_FFFF);
    chk("R4 sticky0", 64'(sticky_ov), 64'h3);
    issue(C_MODE, 0, 0, 0, 0, 4'b0000);
    issue(C_MAC, 0, 0, 32'd1, 32'd2, 4'b0);
    chk_acc("R8 wrap to 48b", 0, 48'h0000_0000_0001);
    chk("R8 V", 64'(flag_v), 64'h1);
  endtask

  task automatic t_fraction_round();
    do_reset();
    issue(C_MODE, 0, 0, 0, 0, 4'b0010);
    issue(C_MAC, 0, 0, 32'd3, 32'h0080_0000, 4'b0);
    chk_acc("R5 no round", 0, 48'd1);
    issue(C_MODE, 0, 0, 0, 0, 4'b0110);
    issue(C_MAC, 1, 0, 32'd3, 32'h0080_0000, 4'b0);
    chk_acc("R5 tie to even up", 1, 48'd2);
    issue(C_MAC, 2, 0, 32'd5, 32'h0080_0000, 4'b0);
    chk_acc("R5 tie stays even", 2, 48'd2);
    issue(C_MAC, 3, 0, 32'd3, 32'h0080_0001, 4'b0);
    chk_acc("R5 above half", 3, 48'd2);
    issue(C_MAC, 0, 0, 32'd1, 32'h007F_FFFF, 4'b0);
    chk_acc("R5 below half", 0, 48'd1);
  endtask

  task automatic t_signed_acc_ovf();
    do_reset();
    issue(C_MODE, 0, 0, 0, 0, 4'b0001);
    burst(0, 32'h4000_0000, 32'h0000_0100, 511);
    chk("R6 no V before limit", 64'(flag_v), 64'h0);
    burst(0, 32'h4000_0000, 32'h0000_0100, 1);
    chk_acc("R6 wrap 48b", 0, 48'h8000_0000_0000);
    chk("R6 V", 64'(flag_v), 64'h1);
    chk("R6 sticky", 64'(sticky_ov), 64'h1);
    issue(C_MODE, 0, 0, 0, 0, 4'b1001);
    burst(1, 32'h4000_0000, 32'h0000_0100, 512);
    chk_acc("R6 clamp 32b extreme", 1, 48'h0000_7FFF_FFFF);
    chk("R6 sticky both", 64'(sticky_ov), 64'h3);
  endtask

  task automatic t_fraction_sat();
    do_reset();
    issue(C_MODE, 0, 0, 0, 0, 4'b1010);
    burst(0, 32'h8000_0000, 32'h8000_0000, 512);
    chk_acc("R7 pos clamp", 0, 48'h7FFF_FFFF_FFFF);
    chk("R7 V", 64'(flag_v), 64'h1);
    burst(1, 32'h8000_0000, 32'h4000_0000, 1024);
    chk_acc("R7 reaches min exactly", 1, 48'h8000_0000_0000);
    chk("R7 sticky1 clear", 64'(sticky_ov), 64'h1);
    burst(1, 32'h8000_0000, 32'h4000_0000, 1);
    chk_acc("R7 neg clamp", 1, 48'h8000_0000_0000);
    chk("R7 sticky1 set", 64'(sticky_ov), 64'h3);
  endtask

  task automatic t_flags();
    do_reset();
    issue(C_MODE, 0, 0, 0, 0, 4'b0001);
    issue(C_MAC, 0, 0, 32'd3, 32'hFFFF_FFFB, 4'b0);
    issue(C_FLAGS, 0, 0, 0, 0, 4'b0);
    chk("R9 negative", 64'({flag_n, flag_z, flag_v, flag_ev}), 64'h8);
    issue(C_MODE, 0, 0, 0, 0, 4'b0001);
    issue(C_FLAGS, 1, 0, 0, 0, 4'b0);
    chk("R9 zero", 64'({flag_n, flag_z, flag_v, flag_ev}), 64'h4);
    issue(C_MODE, 0, 0, 0, 0, 4'b0000);
    issue(C_MAC, 2, 0, 32'h0001_0000, 32'h0001_0000, 4'b0);
    issue(C_FLAGS, 2, 0, 0, 0, 4'b0);
    chk("R10 EV unsigned", 64'({flag_n, flag_z, flag_v, flag_ev}), 64'h1);
    issue(C_MODE, 0, 0, 0, 0, 4'b0001);
    issue(C_FLAGS, 2, 0, 0, 0, 4'b0);
    chk("R10 EV signed", 64'(flag_ev), 64'h1);
    issue(C_MODE, 0, 0, 0, 0, 4'b0010);
    issue(C_FLAGS, 2, 0, 0, 0, 4'b0);
    chk("R10 no EV fractional", 64'(flag_ev), 64'h0);
  endtask

  task automatic t_move();
    do_reset();
    issue(C_MODE, 0, 0, 0, 0, 4'b1001);
    issue(C_MAC, 2, 0, 32'h4000_0000, 32'hFFFF_FC00, 4'b0);
    issue(C_MOVE, 0, 2, 0, 0, 4'b0);
    chk_acc("R11 value copied", 0, 48'hFFFF_8000_0000);
    chk("R11 sticky copied set", 64'(sticky_ov), 64'h5);
    issue(C_MAC, 1, 0, 32'd3, 32'd5, 4'b0);
    issue(C_MOVE, 2, 1, 0, 0, 4'b0);
    chk_acc("R11 value over", 2, 48'd15);
    chk("R11 sticky copied clear", 64'(sticky_ov), 64'h1);
  endtask

  task automatic t_idle();
    do_reset();
    issue(C_MODE, 0, 0, 0, 0, 4'b0001);
    issue(C_MAC, 1, 0, 32'h4000_0000, 32'h0000_0400, 4'b0);
    issue(C_MAC, 3, 0, 32'd7, 32'd6, 4'b0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      cmd_op = 2'(k); cmd_acc = 2'(k + 1); cmd_src = 2'(k);
      cmd_a = 32'hFFFF_0000 + 32'(k); cmd_b = 32'h8000_0000; cmd_mode = 4'hF;
    end
    @(negedge clk);
    chk("R13 done low", 64'(done), 64'h0);
    chk_acc("R13 acc3 held", 3, 48'd42);
    chk_acc("R13 acc1 held", 1, 48'd0);
    chk("R13 sticky held", 64'(sticky_ov), 64'h2);
    chk("R13 mode held", 64'(mode_o), 64'h1);
    chk("R13 flags held", 64'({flag_n, flag_z, flag_v, flag_ev}), 64'h2);
  endtask

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_acc = '0; cmd_src = '0;
    cmd_a = '0; cmd_b = '0; cmd_mode = '0; rd_sel = '0;
    t_reset_state();
    t_signed_basic();
    t_signed_product_ovf();
    t_unsigned();
    t_fraction_round();
    t_signed_acc_ovf();
    t_fraction_sat();
    t_flags();
    t_move();
    t_idle();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule